// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block turns an already decoded addressing mode and its operand bytes into the 16-bit address that an 8-bit-data processor will access. It covers the immediate, absolute, page-zero, indexed, pointer-based and branch-relative modes. A request carries the mode code, the low and high operand bytes, the two index registers and the program counter. The block returns one 16-bit address on a result channel.

Modes that need no memory are computed at once. The three pointer modes use a byte-wide read port with one cycle of latency to fetch a little-endian pointer: the low byte first, then the high byte. Indirect absolute computes the second pointer address with a full 16-bit carry. The two page-zero pointer modes keep the second byte address inside page zero.

Both data interfaces are valid/ready. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its fields are sampled on that edge. Requests offered at other times are ignored. `res_valid` stays high, with `res_addr` held, until an edge where `res_ready` is also high. The block is idle again after that edge. When `res_ready` is held high, `res_valid` is a single-cycle done pulse.

Top module: `ea_resolver`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1, `res_valid` is 0 and `mem_rd_en` is 0.
- R2: For a mode that needs no pointer, `res_valid` is high in the cycle right after the accepting edge, and `mem_rd_en` stays low for the whole request.
- R3: Page zero (code 2) gives {0x00, lo}. Page zero indexed by X (code 5) or by Y (code 6) gives {0x00, (lo + index) mod 256}. The high operand byte is ignored in these modes.
- R4: Immediate (code 0) gives the program counter. Absolute (code 1) gives {hi, lo}. Absolute indexed by X (code 3) or by Y (code 4) gives ({hi, lo} + index) mod 65536.
- R5: Relative (code 10) gives (pc + lo taken as a signed byte) mod 65536, so 0x7F adds 127, 0xF9 adds -7 and 0x80 adds -128.
- R6: Indirect absolute (code 7) reads the byte at {hi, lo} and then the byte at ({hi, lo} + 1) mod 65536. The result is {second byte, first byte}.
- R7: Indexed indirect (code 8) reads at {0x00, (lo + X) mod 256} and then at the next page-zero address, which wraps from 0xFF to 0x00. The result is {second byte, first byte}.
- R8: Indirect indexed (code 9) reads at {0x00, lo} and then at {0x00, (lo + 1) mod 256}. The result is ({second byte, first byte} + Y) mod 65536.
- R9: For a pointer mode, `mem_rd_en` is high in exactly the first two cycles after the accepting edge, and `res_valid` rises in the fourth cycle after that edge.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_addr` hold their values. `req_ready` stays low from the accepting edge until the result has been taken, so a request offered in that time has no effect.
- R11: The mode code is 4 bits wide, with the values 0 to 10 as listed in R3 to R8. Codes 11 to 15 resolve in the same way as absolute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mode | input | 4 | Addressing mode code (R11) |
| req_lo | input | 8 | First operand byte |
| req_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| req_pc | input | 16 | Program counter, used by the immediate and relative modes |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| res_valid | output | 1 | Effective address valid |
| res_ready | input | 1 | Consumer takes the address |
| res_addr | output | 16 | Effective address |

## Verification
The bench offers each request on a falling edge and then counts falling edges after the accepting rising edge. A direct result must be visible on the very first of these falling edges. A pointer result must be visible on the fourth, because it passes through the low-byte read, the high-byte read and the result register in turn. While it waits, the bench records every read strobe and its address, then compares the number of reads and their order with the addresses required for that mode. The back-pressure test holds `res_ready` low for several cycles and offers a rival request during that time. It then checks that the result is unchanged and that nothing is accepted after the handshake.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_ABS  = 4'd1,
    M_ZP   = 4'd2,
    M_ABSX = 4'd3,
    M_ABSY = 4'd4,
    M_ZPX  = 4'd5,
    M_ZPY  = 4'd6,
    M_IND  = 4'd7,
    M_IZX  = 4'd8,
    M_IZY  = 4'd9,
    M_REL  = 4'd10
  } ea_mode_e;
endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ea,
  output logic              is_ptr,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              ptr_zp,
  output logic              post_y
);
  localparam logic [DATA_W-1:0] ZPAGE = '0;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] x_w, y_w, rel_w;
  logic [DATA_W-1:0] zp_x, zp_y;

  assign base  = {hi, lo};
  assign x_w   = {{(ADDR_W-DATA_W){1'b0}}, x};
  assign y_w   = {{(ADDR_W-DATA_W){1'b0}}, y};
  assign rel_w = {{(ADDR_W-DATA_W){lo[DATA_W-1]}}, lo};
  assign zp_x  = lo + x;
  assign zp_y  = lo + y;

  always_comb begin
    ea       = base;
    is_ptr   = 1'b0;
    ptr_addr = base;
    ptr_zp   = 1'b0;
    post_y   = 1'b0;
    case (mode)
      M_IMM:  ea = pc;
      M_ABS:  ea = base;
      M_ZP:   ea = {ZPAGE, lo};
      M_ABSX: ea = base + x_w;
      M_ABSY: ea = base + y_w;
      M_ZPX:  ea = {ZPAGE, zp_x};
      M_ZPY:  ea = {ZPAGE, zp_y};
      M_REL:  ea = pc + rel_w;
      M_IND: begin
        is_ptr   = 1'b1;
        ptr_addr = base;
      end
      M_IZX: begin
        is_ptr   = 1'b1;
        ptr_zp   = 1'b1;
        ptr_addr = {ZPAGE, zp_x};
      end
      M_IZY: begin
        is_ptr   = 1'b1;
        ptr_zp   = 1'b1;
        post_y   = 1'b1;
        ptr_addr = {ZPAGE, lo};
      end
      default: ea = base;
    endcase
  end
endmodule

// File: rtl/ea_ptr_seq.sv
module ea_ptr_seq #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              ptr_zp,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] word
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_LAST} seq_e;

  localparam logic [DATA_W-1:0] ZPAGE = '0;

  seq_e              state;
  logic [ADDR_W-1:0] base_q;
  logic              zp_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] zp_next;

  assign zp_next = base_q[DATA_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      base_q <= '0;
      zp_q   <= 1'b0;
      lo_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_LO;
          base_q <= ptr_addr;
          zp_q   <= ptr_zp;
        end
        S_LO:   state <= S_HI;
        S_HI: begin
          state <= S_LAST;
          lo_q  <= rd_data;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = base_q;
    case (state)
      S_LO: rd_en = 1'b1;
      S_HI: begin
        rd_en   = 1'b1;
        rd_addr = zp_q ? {ZPAGE, zp_next} : base_q + 1'b1;
      end
      default: ;
    endcase
  end

  assign done = (state == S_LAST);
  assign word = {rd_data, lo_q};

  a_r9_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_en);
  a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> state == S_IDLE);
  a_r9_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_en));
  a_r7_zp_second_read: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ptr_zp) |=> ##1 (rd_addr[ADDR_W-1:DATA_W] == '0));
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_mode,
  input  logic [DATA_W-1:0] req_lo,
  input  logic [DATA_W-1:0] req_hi,
  input  logic [DATA_W-1:0] idx_x,
  input  logic [DATA_W-1:0] idx_y,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr
);
  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_OUT} top_e;

  top_e              state;
  logic [ADDR_W-1:0] direct_ea, ptr_addr, word, post_off_q, res_q;
  logic              is_ptr, ptr_zp, post_y, done, accept, start;

  ea_direct_calc #(.DATA_W(DATA_W)) u_calc (
    .mode(req_mode), .lo(req_lo), .hi(req_hi), .x(idx_x), .y(idx_y),
    .pc(req_pc), .ea(direct_ea), .is_ptr(is_ptr), .ptr_addr(ptr_addr),
    .ptr_zp(ptr_zp), .post_y(post_y)
  );

  ea_ptr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ptr_addr(ptr_addr),
    .ptr_zp(ptr_zp), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .rd_data(mem_rd_data), .done(done), .word(word)
  );

  assign req_ready = (state == T_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && is_ptr;
  assign res_valid = (state == T_OUT);
  assign res_addr  = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= T_IDLE;
      res_q      <= '0;
      post_off_q <= '0;
    end else begin
      case (state)
        T_IDLE: if (accept) begin
          if (is_ptr) begin
            state      <= T_WAIT;
            post_off_q <= post_y ? {{(ADDR_W-DATA_W){1'b0}}, idx_y} : '0;
          end else begin
            state <= T_OUT;
            res_q <= direct_ea;
          end
        end
        T_WAIT: if (done) begin
          state <= T_OUT;
          res_q <= word + post_off_q;
        end
        default: if (res_ready) state <= T_IDLE;
      endcase
    end
  end

  a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);
  a_r2_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ptr) |=> res_valid);
  a_r9_done_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> res_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr)));
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/ea_resolver_tb_top.sv
module ea_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, res_ready = 1'b1;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_lo = '0, req_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] req_pc = '0;
  logic        req_ready, mem_rd_en, res_valid;
  logic [15:0] mem_rd_addr, res_addr;
  logic [7:0]  mem_rd_data = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ea_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_lo(req_lo), .req_hi(req_hi), .idx_x(idx_x),
    .idx_y(idx_y), .req_pc(req_pc), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    case (a)
      16'h2345: return 8'hEA;
      16'h2346: return 8'h12;
      16'h00BA: return 8'h12;
      16'h00BB: return 8'hEE;
      16'h00B4: return 8'hEE;
      16'h00B5: return 8'h12;
      default:  return a[7:0] ^ a[15:8] ^ 8'h5A;
    endcase
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_rd_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  mode;
    logic [7:0]  lo, hi, x, y;
    logic [15:0] pc, exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  8'h00, 8'h00, 8'h00, 8'h00, 16'h8000, 16'h8000},
    '{4'd1,  8'h32, 8'h3E, 8'h00, 8'h00, 16'h0000, 16'h3E32},
    '{4'd2,  8'h23, 8'hFF, 8'h00, 8'h00, 16'h0000, 16'h0023},
    '{4'd3,  8'h53, 8'hF4, 8'h03, 8'h00, 16'h0000, 16'hF456},
    '{4'd4,  8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0000, 16'h0010},
    '{4'd5,  8'hF0, 8'h44, 8'h20, 8'h00, 16'h0000, 16'h0010},
    '{4'd6,  8'h10, 8'h44, 8'h00, 8'h05, 16'h0000, 16'h0015},
    '{4'd10, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h107F},
    '{4'd10, 8'hF9, 8'h00, 8'h00, 8'h00, 16'h1000, 16'h0FF9},
    '{4'd10, 8'h80, 8'h00, 8'h00, 8'h00, 16'h0040, 16'hFFC0},
    '{4'd7,  8'h45, 8'h23, 8'h00, 8'h00, 16'h0000, 16'h12EA},
    '{4'd7,  8'hFF, 8'h12, 8'h00, 8'h00, 16'h0000, 16'h49B7},
    '{4'd8,  8'hB4, 8'h77, 8'h06, 8'h00, 16'h0000, 16'hEE12},
    '{4'd8,  8'hFE, 8'h77, 8'h03, 8'h00, 16'h0000, 16'h585B},
    '{4'd8,  8'hF0, 8'h77, 8'h0F, 8'h00, 16'h0000, 16'h5AA5},
    '{4'd9,  8'hB4, 8'h77, 8'h00, 8'h06, 16'h0000, 16'h12F4},
    '{4'd9,  8'hFF, 8'h77, 8'h00, 8'h10, 16'h0000, 16'h5AB5},
    '{4'd9,  8'hB4, 8'h77, 8'h00, 8'h20, 16'h0000, 16'h130E},
    '{4'd12, 8'h34, 8'h12, 8'h00, 8'h00, 16'h0000, 16'h1234}
  };

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1, 4'd3, 4'd4: return "R4";
      4'd2, 4'd5, 4'd6:       return "R3";
      4'd10:                  return "R5";
      4'd7:                   return "R6";
      4'd8:                   return "R7";
      4'd9:                   return "R8";
      default:                return "R11";
    endcase
  endfunction

  function automatic bit is_ptr_mode(input logic [3:0] m);
    return (m == 4'd7) || (m == 4'd8) || (m == 4'd9);
  endfunction

  task automatic offer(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1;
    req_mode = v.mode; req_lo = v.lo; req_hi = v.hi;
    idx_x = v.x; idx_y = v.y; req_pc = v.pc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int wait_n = 0;
    int nrd = 0;
    logic [15:0] rda [2];
    logic [15:0] p0, p1;
    rda[0] = '0; rda[1] = '0;
    offer(v);
    while (!res_valid && wait_n < 10) begin
      if (mem_rd_en) begin
        if (nrd < 2) rda[nrd] = mem_rd_addr;
        nrd++;
      end
      wait_n++;
      @(negedge clk);
    end
    check(res_addr == v.exp, req_of(v.mode), {16'h0, res_addr}, {16'h0, v.exp});
    if (is_ptr_mode(v.mode)) begin
      check(wait_n == 3, "R9 latency", wait_n, 3);
      check(nrd == 2, "R9 read count", nrd, 2);
      if (v.mode == 4'd7) p0 = {v.hi, v.lo};
      else if (v.mode == 4'd8) p0 = {8'h00, v.lo + v.x};
      else p0 = {8'h00, v.lo};
      p1 = (v.mode == 4'd7) ? p0 + 16'd1 : {8'h00, p0[7:0] + 8'd1};
      check(rda[0] == p0, req_of(v.mode), {16'h0, rda[0]}, {16'h0, p0});
      check(rda[1] == p1, req_of(v.mode), {16'h0, rda[1]}, {16'h0, p1});
    end else begin
      check(wait_n == 0, "R2 latency", wait_n, 0);
      check(nrd == 0, "R2 no read", nrd, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t bp;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    check(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && res_valid == 1'b0 && mem_rd_en == 1'b0,
          "R1 idle after reset", {req_ready, res_valid, mem_rd_en}, 3'b100);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: back-pressure with a rival request offered while busy
    res_ready = 1'b0;
    bp = VECS[15];
    offer(bp);
    repeat (3) @(negedge clk);
    check(res_valid == 1'b1, "R10 valid while stalled", res_valid, 1);
    held = res_addr;
    req_valid = 1'b1; req_mode = 4'd1; req_lo = 8'h11; req_hi = 8'h22;
    repeat (3) begin
      @(negedge clk);
      check(res_valid == 1'b1 && res_addr == held, "R10 hold",
            {16'h0, res_addr}, {16'h0, held});
      check(req_ready == 1'b0, "R10 busy", req_ready, 0);
    end
    req_valid = 1'b0;
    check(res_addr == 16'h12F4, "R10 held value", {16'h0, res_addr}, 32'h12F4);
    res_ready = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && req_ready == 1'b1, "R10 rival ignored",
          {res_valid, req_ready}, 2'b01);
    repeat (2) @(negedge clk);
    check(res_valid == 1'b0, "R10 nothing pending", res_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule